// File: doc/BRIEF.md
# Banked Split-Byte Sample Buffer

This block collects 12-bit conversion results from a multi-channel sampling loop and keeps them in four byte-wide FIFOs. Each FIFO holds eight entries. Every result is cut into two bytes. The low byte and the high byte go into two FIFOs that form a pair, and both are written in the same cycle. The top bit of the channel number picks the pair. Channels 8 to 15 fill the upper pair and channels 0 to 7 fill the lower pair.

A capture is taken only when the sample-done strobe and the bank enable are both high. The bank enable comes from the channel counter and changes in step with sample-done. Each FIFO's load is formed from its own full flag and that enable, so a write to a full FIFO is dropped.

The channels arrive in descending order, so the lower low-byte FIFO is the last one to fill in a scan. The interrupt rises when that FIFO becomes full. Software then drains all four FIFOs through their read ports, and the interrupt drops once every FIFO is empty.

Top module: `sample_bank_buffer`

## Requirements
- R1: After reset the outputs are all zero: every full flag, every overflow flag, the interrupt and every read data byte.
- R2: A result is stored only on a cycle where `cap_valid` and `bank_en` are both high. On any other cycle no FIFO gains an entry.
- R3: The low-byte FIFO of a pair receives result bits 7:0. The high-byte FIFO of the same pair receives bits 11:8 with zeros in bits 7:4. Both bytes are written on the same clock edge.
- R4: FIFO index i is exposed on `fifo_full[i]`, `ovf[i]`, `rd_en[i]` and `rd_data[8*i+7:8*i]`. The FIFOs are assigned as follows:
  - When channel bit 3 is 1, the result goes to FIFO 2 (low byte) and FIFO 3 (high byte).
  - When channel bit 3 is 0, the result goes to FIFO 0 (low byte) and FIFO 1 (high byte).
- R5: `fifo_full[i]` is high exactly while FIFO i holds 8 entries. A write to a full FIFO is dropped and sets `ovf[i]`, which stays high until reset.
- R6: A read of a non-empty FIFO returns its oldest entry on `rd_data` one edge after `rd_en`, in write order. A read of an empty FIFO returns zero and moves no pointer. When no read is requested, `rd_data` holds its value.
- R7: `irq` rises on the same edge on which FIFO 0 becomes full.
- R8: `irq` stays high until all four FIFOs are empty, and it drops on the edge that follows.
- R9: A result presented at clock edge N is held in a capture register at that edge and enters its FIFOs at edge N+1. The full flags and stored data reflect it from edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Sample-done capture strobe |
| cap_data | input | 12 | Conversion result |
| cap_chan | input | 4 | Channel number of the result |
| bank_en | input | 1 | Write enable from the channel counter |
| fifo_full | output | 4 | Full flag per FIFO |
| ovf | output | 4 | Sticky overflow flag per FIFO |
| rd_en | input | 4 | Read request per FIFO |
| rd_data | output | 32 | Read byte per FIFO, FIFO i in bits 8i+7:8i |
| irq | output | 1 | Scan-complete interrupt |

## Verification
The checks follow the latency of each result:
- A capture appears in the full flags and stored data two edges after it is driven: one edge into the capture register and one edge into the FIFOs.
- Read data and the overflow flag are due one edge after their cause.
- The interrupt rises on the same edge as FIFO 0's full flag. It drops one edge after all four FIFOs are empty.

The bench drives inputs at the falling edge and samples one nanosecond after the rising edge. A reference model advances once per edge with the same pipeline, so every comparison is made in the cycle the result is due.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  localparam int SMP_W   = 12;
  localparam int BYTE_W  = 8;
  localparam int NUM_FIFO = 4;

  function automatic logic [BYTE_W-1:0] lo_part(input logic [SMP_W-1:0] d);
    return d[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] hi_part(input logic [SMP_W-1:0] d);
    return BYTE_W'(d[SMP_W-1:BYTE_W]);
  endfunction
endpackage

// File: rtl/sbb_byte_fifo.sv
module sbb_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty,
  output logic         ovf,
  output logic         fill_evt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          wr_ok, rd_ok;

  assign wr_ok    = wr_req && !full;
  assign rd_ok    = rd_req && !empty;
  assign fill_evt = wr_ok && !rd_ok && (cnt == CW'(DEPTH - 1));

  always_comb begin
    cnt_nxt = cnt;
    if (wr_ok && !rd_ok) cnt_nxt = cnt + 1'b1;
    else if (!wr_ok && rd_ok) cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      full    <= 1'b0;
      empty   <= 1'b1;
      ovf     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (rd_req) rd_data <= rd_ok ? mem[rp] : '0;
      if (wr_req && full) ovf <= 1'b1;
      cnt   <= cnt_nxt;
      full  <= (cnt_nxt == CW'(DEPTH));
      empty <= (cnt_nxt == '0);
    end
  end

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  a_r5_drop_keeps_full: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req && !rd_req) |=> full);
  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty) |=> (rd_data == '0));
endmodule

// File: rtl/sbb_capture_stage.sv
module sbb_capture_stage
  import sbb_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cap_valid,
  input  logic                         bank_en,
  input  logic [CH_W-1:0]              cap_chan,
  input  logic [SMP_W-1:0]             cap_data,
  output logic [NUM_FIFO-1:0]          wr_req,
  output logic [NUM_FIFO*BYTE_W-1:0]   wr_bytes
);
  logic take;
  logic bank_hi;
  assign take    = cap_valid && bank_en;
  assign bank_hi = cap_chan[CH_W-1];

  for (genvar p = 0; p < NUM_FIFO / 2; p++) begin : g_pair
    localparam int LO = 2 * p;
    localparam int HI = 2 * p + 1;
    always_ff @(posedge clk) begin
      if (rst) begin
        wr_req[LO] <= 1'b0;
        wr_req[HI] <= 1'b0;
        wr_bytes[LO*BYTE_W +: BYTE_W] <= '0;
        wr_bytes[HI*BYTE_W +: BYTE_W] <= '0;
      end else begin
        wr_req[LO] <= take && (bank_hi == (p == 1));
        wr_req[HI] <= take && (bank_hi == (p == 1));
        wr_bytes[LO*BYTE_W +: BYTE_W] <= lo_part(cap_data);
        wr_bytes[HI*BYTE_W +: BYTE_W] <= hi_part(cap_data);
      end
    end
  end

  a_r2_no_store_without_en: assert property (@(posedge clk) disable iff (rst)
    !(cap_valid && bank_en) |=> (wr_req == '0));
  a_r4_pair_written_together: assert property (@(posedge clk) disable iff (rst)
    (wr_req == 4'b0000) || (wr_req == 4'b0011) || (wr_req == 4'b1100));
endmodule

// File: rtl/sbb_irq_ctrl.sv
module sbb_irq_ctrl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         last_fill,
  input  logic [N-1:0] empty,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else if (last_fill) irq <= 1'b1;
    else if (&empty) irq <= 1'b0;
  end

  a_r8_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !(&empty)) |=> irq);
  a_r8_irq_clears: assert property (@(posedge clk) disable iff (rst)
    (irq && (&empty)) |=> !irq);
endmodule

// File: rtl/sample_bank_buffer.sv
module sample_bank_buffer
  import sbb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CH_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cap_valid,
  input  logic [SMP_W-1:0]            cap_data,
  input  logic [CH_W-1:0]             cap_chan,
  input  logic                        bank_en,
  output logic [NUM_FIFO-1:0]         fifo_full,
  output logic [NUM_FIFO-1:0]         ovf,
  input  logic [NUM_FIFO-1:0]         rd_en,
  output logic [NUM_FIFO*BYTE_W-1:0]  rd_data,
  output logic                        irq
);
  logic [NUM_FIFO-1:0]        wr_req;
  logic [NUM_FIFO*BYTE_W-1:0] wr_bytes;
  logic [NUM_FIFO-1:0]        empty;
  logic [NUM_FIFO-1:0]        fill_evt;

  sbb_capture_stage #(.CH_W(CH_W)) cap_i (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .bank_en(bank_en),
    .cap_chan(cap_chan), .cap_data(cap_data),
    .wr_req(wr_req), .wr_bytes(wr_bytes)
  );

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_fifo
    sbb_byte_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst(rst),
      .wr_req(wr_req[i]), .wr_data(wr_bytes[i*BYTE_W +: BYTE_W]),
      .rd_req(rd_en[i]), .rd_data(rd_data[i*BYTE_W +: BYTE_W]),
      .full(fifo_full[i]), .empty(empty[i]), .ovf(ovf[i]),
      .fill_evt(fill_evt[i])
    );
  end

  sbb_irq_ctrl #(.N(NUM_FIFO)) irq_i (
    .clk(clk), .rst(rst), .last_fill(fill_evt[0]), .empty(empty), .irq(irq)
  );

  a_r7_irq_with_last_full: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_full[0]) |-> irq);
  a_r5_full_not_empty: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fifo_full[0], empty[0]}));
endmodule

// File: tb/sample_bank_buffer_tb_top.sv
module sample_bank_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cap_valid;
  logic [11:0] cap_data;
  logic [3:0]  cap_chan;
  logic        bank_en;
  logic [3:0]  fifo_full, ovf, rd_en;
  logic [31:0] rd_data;
  logic        irq;

  always #2.5 clk = ~clk;

  sample_bank_buffer dut_i (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_data(cap_data),
    .cap_chan(cap_chan), .bank_en(bank_en), .fifo_full(fifo_full),
    .ovf(ovf), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_mem [4][8];
  int         m_cnt [4], m_wp [4], m_rp [4];
  logic [7:0] m_rd  [4];
  logic [3:0] m_ovf;
  logic       m_irq, st_v;
  logic [3:0] st_ch;
  logic [11:0] st_d;

  function automatic logic [7:0] exp_byte(input int idx, input logic [11:0] d);
    return (idx % 2 == 1) ? {4'b0000, d[11:8]} : d[7:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_cnt[i] = 0; m_wp[i] = 0; m_rp[i] = 0; m_rd[i] = 8'h00;
    end
    m_ovf = 4'h0; m_irq = 1'b0; st_v = 1'b0; st_ch = 4'h0; st_d = 12'h000;
  endtask

  task automatic model_edge(input logic cv, input logic be, input logic [3:0] ch,
                            input logic [11:0] d, input logic [3:0] re);
    int  pre [4];
    logic all_empty, set;
    all_empty = 1'b1;
    set = 1'b0;
    for (int i = 0; i < 4; i++) begin
      pre[i] = m_cnt[i];
      if (pre[i] != 0) all_empty = 1'b0;
    end
    for (int i = 0; i < 4; i++) begin
      logic wr, wok, rok;
      wr  = st_v && (st_ch[3] ? (i >= 2) : (i < 2));
      wok = wr && (pre[i] < 8);
      rok = re[i] && (pre[i] > 0);
      if (re[i]) begin
        m_rd[i] = rok ? m_mem[i][m_rp[i]] : 8'h00;
        if (rok) begin m_rp[i] = (m_rp[i] + 1) % 8; m_cnt[i]--; end
      end
      if (wok) begin
        m_mem[i][m_wp[i]] = exp_byte(i, st_d);
        m_wp[i] = (m_wp[i] + 1) % 8;
        m_cnt[i]++;
      end
      if (wr && pre[i] == 8) m_ovf[i] = 1'b1;
      if (i == 0 && wok && !rok && pre[0] == 7) set = 1'b1;
    end
    m_irq = set ? 1'b1 : (all_empty ? 1'b0 : m_irq);
    st_v = cv && be; st_ch = ch; st_d = d;
  endtask

  task automatic step(input logic cv, input logic be, input logic [3:0] ch,
                      input logic [11:0] d, input logic [3:0] re);
    @(negedge clk);
    cap_valid = cv; bank_en = be; cap_chan = ch; cap_data = d; rd_en = re;
    model_edge(cv, be, ch, d, re);
    @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) begin
      chk($sformatf("R5 full[%0d]", i), 32'(fifo_full[i]), 32'(m_cnt[i] == 8));
      if (re[i]) chk($sformatf("R6 rd_data[%0d]", i), 32'(rd_data[8*i +: 8]), 32'(m_rd[i]));
    end
    chk("R5 ovf", 32'(ovf), 32'(m_ovf));
    chk("R7 R8 irq", 32'(irq), 32'(m_irq));
  endtask

  initial begin
    #150000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cap_valid = 0; bank_en = 0; cap_chan = 0; cap_data = 0; rd_en = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 full", 32'(fifo_full), 32'h0);
    chk("R1 ovf", 32'(ovf), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
    @(negedge clk); rst = 1'b0;

    // R2: strobes without the enable, or the enable without a strobe, store nothing
    step(1, 0, 4'd15, 12'hFFF, 4'h0);
    step(0, 1, 4'd3,  12'h123, 4'h0);
    step(0, 0, 4'd0,  12'h000, 4'hF);
    chk("R2 empty read after ignored strobe", rd_data, 32'h0);

    // R9: a capture lands in the FIFOs two edges after it is driven
    step(1, 1, 4'd15, 12'hABC, 4'h0);
    step(0, 0, 4'd0, 12'h000, 4'h0);
    step(0, 0, 4'd0, 12'h000, 4'hC);
    chk("R3 R4 R9 upper low byte", 32'(rd_data[23:16]), 32'hBC);
    chk("R3 R4 R9 upper high byte", 32'(rd_data[31:24]), 32'h0A);

    // R7: a full scan of channels 15 down to 0
    for (int c = 15; c >= 0; c--) step(1, 1, 4'(c), 12'(c * 273 + 5), 4'h0);
    step(0, 0, 4'd0, 12'h000, 4'h0);
    chk("R5 R7 all full after scan", 32'(fifo_full), 32'hF);
    chk("R7 irq after scan", 32'(irq), 32'h1);
    // R5: one more write into a full pair is dropped and flags overflow
    step(1, 1, 4'd2, 12'h777, 4'h0);
    step(0, 0, 4'd0, 12'h000, 4'h0);
    chk("R5 overflow lower pair", 32'(ovf), 32'h3);
    // R6 R8: drain all, then check irq release
    for (int k = 0; k < 9; k++) step(0, 0, 4'd0, 12'h000, 4'hF);
    step(0, 0, 4'd0, 12'h000, 4'h0);
    chk("R8 irq released", 32'(irq), 32'h0);

    // Random traffic against the model
    for (int k = 0; k < 1500; k++) begin
      logic [3:0] re;
      re = 4'h0;
      for (int i = 0; i < 4; i++) re[i] = ($urandom % 100) < 30;
      step(($urandom % 100) < 55, ($urandom % 100) < 85,
           4'($urandom % 16), 12'($urandom), re);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule